// File: doc/BRIEF.md
# Nested Prioritized Event Controller

This block decides which event the processor core should service next. Requests arrive from five kinds of source: an emulation request, a reset event, a non-maskable interrupt, a synchronous fault (exception), and a set of general interrupt levels. Peripheral request lines are asynchronous. They first pass through a system stage, which synchronizes them with two flip-flops, masks them line by line, and steers each one onto a core interrupt level chosen by a small write port. A core stage latches every request as pending and ranks the pending classes. It grants the best one only when it outranks every handler already in service, so that handlers nest.

Each class has a vector index: 0 is emulation, 1 is the reset event, 2 is the non-maskable interrupt, 3 is the exception, and 4+k is interrupt level k. A lower index means a higher priority. When a class is granted, the program counter on `pc_in` is copied into that class's return-address register. A return strobe for the handler now in service retires it. A fault flag also raises `exc_kill` at once, so the faulting instruction can be stopped from completing.

Top module: `evc_top`

## Requirements
- R1: Vector indices are emulation 0, reset event 1, non-maskable interrupt 2, exception 3, and interrupt level k at 4+k. When several classes are pending and none is active, the lowest index is granted first and the others wait.
- R2: A core request sampled at clock edge n, with nothing active, gives `grant_valid` high with `grant_vec` set to its index for exactly the cycle after edge n+1.
- R3: A pending class is granted only if its index is strictly lower than every set bit of `active`. A grant sets that class's bit in `active`, so a lower-index event preempts the handler in service while a higher-index one waits.
- R4: `ret_strobe[c]` clears bit c of `active` only when c is the lowest-index set bit. A strobe for any other class, or any strobe while `active` is zero, changes nothing.
- R5: On a grant of class c, the field `ret_addr[c*PC_W +: PC_W]` takes the value of `pc_in` from the cycle in which the decision is made, the cycle before `grant_valid` rises. Every other field keeps its value.
- R6: The non-maskable interrupt (index 2) is raised by `nmi_pin` or by `wdog_timeout`. Either one alone is enough.
- R7: `exc_kill` is high in the same cycle as `fault_align` or `fault_undef`, and either flag makes the exception (index 3) pending.
- R8: An unmasked peripheral line pulsed high for one cycle before edge n is granted as index 4 plus its assigned level, with `grant_valid` high in the cycle after edge n+3. Two of those edges are synchronizer delay.
- R9: A write with `cfg_we` sets the mask bit of line `cfg_line` to `cfg_mask` (1 = masked) and its level to `cfg_level`. A masked line never raises a request. After reset every line is masked and assigned to level 0.
- R10: `swi_raise[k]` makes interrupt level k (index 4+k) pending without any peripheral line.
- R11: After reset `grant_valid`, `active` and every return-address field are zero.
- R12: When a grant and a valid return fall on the same edge, both take effect. The grant is ranked against `active` as it stood before that return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| emu_req | input | 1 | Emulation request (index 0) |
| reset_evt_req | input | 1 | Reset event request (index 1) |
| nmi_pin | input | 1 | External non-maskable interrupt |
| wdog_timeout | input | 1 | Watchdog timeout, also raises the non-maskable interrupt |
| fault_align | input | 1 | Alignment fault flag |
| fault_undef | input | 1 | Undefined-instruction fault flag |
| periph_req | input | NLINES | Asynchronous peripheral request lines |
| swi_raise | input | NLVL | Software raise, one per interrupt level |
| cfg_we | input | 1 | Configuration write enable |
| cfg_line | input | clog2(NLINES) | Line being configured |
| cfg_mask | input | 1 | Mask value to write (1 = masked) |
| cfg_level | input | clog2(NLVL) | Interrupt level to assign |
| pc_in | input | PC_W | Current program counter |
| ret_strobe | input | NLVL+4 | Return-from-event strobe per class |
| exc_kill | output | 1 | Stops the faulting instruction |
| grant_valid | output | 1 | One-cycle grant pulse |
| grant_vec | output | clog2(NLVL+5) | Index of the granted class |
| active | output | NLVL+4 | Classes currently in service |
| ret_addr | output | (NLVL+4)*PC_W | Return address of each class, class c at c*PC_W |

## Verification
A grant and a return can fall on the same clock edge. The bench provokes this by letting interrupt level 2 enter service, making level 0 pending, and then strobing the return of level 2 in the very cycle in which level 0 is being decided. It then expects a grant of index 4 and an `active` vector holding only bit 4. It also sweeps every ordered pair of classes raised together, every line-to-level mapping with its exact latency, and every line while masked.

// File: rtl/evc_pkg.sv
package evc_pkg;
    // Fixed event classes; the index is the rank (lower wins).
    localparam int CLS_EMU   = 0;
    localparam int CLS_RST   = 1;
    localparam int CLS_NMI   = 2;
    localparam int CLS_EXC   = 3;
    localparam int NUM_FIXED = 4;
endpackage

// File: rtl/evc_sys_stage.sv
module evc_sys_stage #(
    parameter int NLINES = 8,
    parameter int NLVL   = 4,
    localparam int LW    = (NLINES > 1) ? $clog2(NLINES) : 1,
    localparam int VW    = (NLVL > 1) ? $clog2(NLVL) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] line_in,
    input  logic              cfg_we,
    input  logic [LW-1:0]     cfg_line,
    input  logic              cfg_mask,
    input  logic [VW-1:0]     cfg_level,
    output logic [NLVL-1:0]   lvl_req
);
    typedef struct packed {
        logic [NLINES-1:0]         sync1;
        logic [NLINES-1:0]         sync2;
        logic [NLINES-1:0]         mask;
        logic [NLINES-1:0][VW-1:0] map;
    } sys_st_t;

    sys_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.sync1 = line_in;
        st_d.sync2 = st_q.sync1;
        if (cfg_we) begin
            st_d.mask[cfg_line] = cfg_mask;
            st_d.map[cfg_line]  = cfg_level;
        end
        for (int k = 0; k < NLVL; k++) begin
            lvl_req[k] = 1'b0;
            for (int l = 0; l < NLINES; l++) begin
                if (st_q.sync2[l] && !st_q.mask[l] && (st_q.map[l] == VW'(k)))
                    lvl_req[k] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sync1 <= '0;
            st_q.sync2 <= '0;
            st_q.mask  <= '1;
            st_q.map   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (&st_q.mask) |-> (lvl_req == '0)); // R9

    AST_CFG_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (st_q.mask[$past(cfg_line)] == $past(cfg_mask))); // R9
endmodule

// File: rtl/evc_core_stage.sv
module evc_core_stage #(
    parameter int NCLS = 8,
    localparam int CW  = $clog2(NCLS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCLS-1:0] req,
    input  logic [NCLS-1:0] ret_strobe,
    output logic [NCLS-1:0] take,
    output logic            grant_valid,
    output logic [CW-1:0]   grant_vec,
    output logic [NCLS-1:0] active
);
    typedef struct packed {
        logic [NCLS-1:0] pend;
        logic [NCLS-1:0] act;
        logic            gv;
        logic [CW-1:0]   gvec;
    } core_st_t;

    core_st_t        st_d, st_q;
    logic [CW-1:0]   act_top;
    logic [CW-1:0]   cand;
    logic            win;
    logic [NCLS-1:0] ret_clr;

    always_comb begin
        st_d    = st_q;
        act_top = CW'(NCLS);
        cand    = CW'(NCLS);
        for (int i = NCLS - 1; i >= 0; i--) begin
            if (st_q.act[i])  act_top = CW'(i);
            if (st_q.pend[i]) cand    = CW'(i);
        end
        win = (cand < act_top);
        for (int i = 0; i < NCLS; i++) begin
            take[i]    = win && (cand == CW'(i));
            ret_clr[i] = ret_strobe[i] && (act_top == CW'(i));
        end
        st_d.pend = (st_q.pend & ~take) | req;
        st_d.act  = (st_q.act & ~ret_clr) | take;
        st_d.gv   = win;
        st_d.gvec = win ? cand : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign grant_valid = st_q.gv;
    assign grant_vec   = st_q.gvec;
    assign active      = st_q.act;

    AST_TAKE_MARKS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (|take) |=> (st_q.gv && ((st_q.act & $past(take)) != '0))); // R3

    AST_ACTIVE_GROWS_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(st_q.act & ~$past(st_q.act)) <= 1)); // R3

    AST_RETURN_CLEARS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones($past(st_q.act) & ~st_q.act) <= 1)); // R4

    AST_IDLE_PEND_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.pend != '0) && (st_q.act == '0)) |=> st_q.gv); // R2
endmodule

// File: rtl/evc_ret_bank.sv
module evc_ret_bank #(
    parameter int NCLS = 8,
    parameter int PC_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NCLS-1:0]           load,
    input  logic [PC_W-1:0]           pc_in,
    output logic [NCLS*PC_W-1:0]      ret_addr
);
    typedef struct packed {
        logic [NCLS-1:0][PC_W-1:0] ra;
    } ret_st_t;

    ret_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NCLS; i++) begin
            if (load[i]) st_d.ra[i] = pc_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ret_addr = st_q.ra;

    for (genvar g = 0; g < NCLS; g++) begin : g_hold
        AST_RET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !load[g] |=> $stable(st_q.ra[g])); // R5
        AST_RET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            load[g] |=> (st_q.ra[g] == $past(pc_in))); // R5
    end
endmodule

// File: rtl/evc_top.sv
module evc_top #(
    parameter int NLINES = 8,
    parameter int NLVL   = 4,
    parameter int PC_W   = 16,
    localparam int NCLS  = evc_pkg::NUM_FIXED + NLVL,
    localparam int CW    = $clog2(NCLS + 1),
    localparam int LW    = (NLINES > 1) ? $clog2(NLINES) : 1,
    localparam int VW    = (NLVL > 1) ? $clog2(NLVL) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 emu_req,
    input  logic                 reset_evt_req,
    input  logic                 nmi_pin,
    input  logic                 wdog_timeout,
    input  logic                 fault_align,
    input  logic                 fault_undef,
    input  logic [NLINES-1:0]    periph_req,
    input  logic [NLVL-1:0]      swi_raise,
    input  logic                 cfg_we,
    input  logic [LW-1:0]        cfg_line,
    input  logic                 cfg_mask,
    input  logic [VW-1:0]        cfg_level,
    input  logic [PC_W-1:0]      pc_in,
    input  logic [NCLS-1:0]      ret_strobe,
    output logic                 exc_kill,
    output logic                 grant_valid,
    output logic [CW-1:0]        grant_vec,
    output logic [NCLS-1:0]      active,
    output logic [NCLS*PC_W-1:0] ret_addr
);
    import evc_pkg::*;

    logic [NLVL-1:0] lvl_req;
    logic [NCLS-1:0] core_req;
    logic [NCLS-1:0] take;

    evc_sys_stage #(.NLINES(NLINES), .NLVL(NLVL)) u_sys (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (periph_req),
        .cfg_we   (cfg_we),
        .cfg_line (cfg_line),
        .cfg_mask (cfg_mask),
        .cfg_level(cfg_level),
        .lvl_req  (lvl_req)
    );

    always_comb begin
        core_req          = '0;
        core_req[CLS_EMU] = emu_req;
        core_req[CLS_RST] = reset_evt_req;
        core_req[CLS_NMI] = nmi_pin | wdog_timeout;
        core_req[CLS_EXC] = fault_align | fault_undef;
        for (int k = 0; k < NLVL; k++)
            core_req[NUM_FIXED + k] = lvl_req[k] | swi_raise[k];
        exc_kill = fault_align | fault_undef;
    end

    evc_core_stage #(.NCLS(NCLS)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (core_req),
        .ret_strobe (ret_strobe),
        .take       (take),
        .grant_valid(grant_valid),
        .grant_vec  (grant_vec),
        .active     (active)
    );

    evc_ret_bank #(.NCLS(NCLS), .PC_W(PC_W)) u_ret (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (take),
        .pc_in   (pc_in),
        .ret_addr(ret_addr)
    );

    AST_NMI_EITHER_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        ((nmi_pin || wdog_timeout) && active == '0 && !take[CLS_EMU] && !take[CLS_RST]
         && !$past(emu_req) && !$past(reset_evt_req)) |=> ##1 (active[CLS_NMI] || active[CLS_EMU] || active[CLS_RST])); // R6
endmodule

// File: tb/evc_top_bench.sv
`timescale 1ns/1ps
module evc_top_bench;
    localparam int NLINES = 8;
    localparam int NLVL   = 4;
    localparam int PC_W   = 16;
    localparam int NCLS   = 4 + NLVL;
    localparam int CW     = $clog2(NCLS + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic emu_req = 0, reset_evt_req = 0, nmi_pin = 0, wdog_timeout = 0;
    logic fault_align = 0, fault_undef = 0;
    logic [NLINES-1:0] periph_req = '0;
    logic [NLVL-1:0]   swi_raise = '0;
    logic cfg_we = 0, cfg_mask = 0;
    logic [2:0] cfg_line = '0;
    logic [1:0] cfg_level = '0;
    logic [PC_W-1:0] pc_in = '0;
    logic [NCLS-1:0] ret_strobe = '0;
    logic exc_kill, grant_valid;
    logic [CW-1:0] grant_vec;
    logic [NCLS-1:0] active;
    logic [NCLS*PC_W-1:0] ret_addr;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    evc_top u_evc_top (
        .clk(clk), .rst_n(rst_n), .emu_req(emu_req), .reset_evt_req(reset_evt_req),
        .nmi_pin(nmi_pin), .wdog_timeout(wdog_timeout), .fault_align(fault_align),
        .fault_undef(fault_undef), .periph_req(periph_req), .swi_raise(swi_raise),
        .cfg_we(cfg_we), .cfg_line(cfg_line), .cfg_mask(cfg_mask), .cfg_level(cfg_level),
        .pc_in(pc_in), .ret_strobe(ret_strobe), .exc_kill(exc_kill),
        .grant_valid(grant_valid), .grant_vec(grant_vec), .active(active), .ret_addr(ret_addr)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input int c, input logic v);
        case (c)
            0: emu_req = v;
            1: reset_evt_req = v;
            2: nmi_pin = v;
            3: fault_align = v;
            default: swi_raise[c-4] = v;
        endcase
    endtask

    // Pulse class c for one cycle; returns at the negedge after the sampling edge.
    task automatic raise(input int c);
        @(negedge clk); drive(c, 1'b1);
        @(negedge clk); drive(c, 1'b0);
    endtask

    task automatic retire(input int c);
        @(negedge clk); ret_strobe[c] = 1'b1;
        @(negedge clk); ret_strobe = '0;
    endtask

    task automatic cfg(input int line, input logic m, input int lvl);
        @(negedge clk);
        cfg_we = 1'b1; cfg_line = 3'(line); cfg_mask = m; cfg_level = 2'(lvl);
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic expect_grant(input int c, input logic [NCLS-1:0] act_exp, input string tag);
        chk(grant_valid && grant_vec == CW'(c), tag, {grant_valid, grant_vec}, {1'b1, CW'(c)});
        chk(active == act_exp, tag, active, act_exp);
    endtask

    function automatic logic [PC_W-1:0] ra(input int c);
        return ret_addr[c*PC_W +: PC_W];
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(!grant_valid && active == '0, "R11 outputs", {grant_valid, active}, 0);
        chk(ret_addr == '0, "R11 ret_addr", ret_addr, 0);

        // R1 R5: every ordered pair raised together
        for (int i = 0; i < NCLS; i++) begin
            for (int j = i + 1; j < NCLS; j++) begin
                pc_in = 16'hA000 + 16'(i);
                @(negedge clk); drive(i, 1'b1); drive(j, 1'b1);
                @(negedge clk); drive(i, 1'b0); drive(j, 1'b0);
                chk(!grant_valid, "R2 not before edge n+1", grant_valid, 0);
                @(negedge clk);
                expect_grant(i, NCLS'(1) << i, "R1 first of pair");
                pc_in = 16'hA000 + 16'(j);
                retire(i);
                chk(active == '0 && !grant_valid, "R4 retire first", active, 0);
                @(negedge clk);
                expect_grant(j, NCLS'(1) << j, "R1 second of pair");
                chk(ra(i) == 16'hA000 + 16'(i) && ra(j) == 16'hA000 + 16'(j), "R5 ret addr",
                    {ra(i), ra(j)}, {16'hA000 + 16'(i), 16'hA000 + 16'(j)});
                retire(j);
                chk(active == '0, "R4 retire second", active, 0);
            end
        end

        // R6: watchdog alone, then pin alone
        pc_in = 16'h0B0B;
        @(negedge clk); wdog_timeout = 1'b1;
        @(negedge clk); wdog_timeout = 1'b0;
        @(negedge clk);
        expect_grant(2, 8'h04, "R6 watchdog");
        retire(2);
        raise(2);
        @(negedge clk);
        expect_grant(2, 8'h04, "R6 pin");
        retire(2);

        // R7: undefined-instruction fault
        @(negedge clk); fault_undef = 1'b1;
        #1 chk(exc_kill, "R7 kill same cycle", exc_kill, 1);
        @(negedge clk); fault_undef = 1'b0;
        #1 chk(!exc_kill, "R7 kill drops", exc_kill, 0);
        @(negedge clk);
        expect_grant(3, 8'h08, "R7 exception pends");
        retire(3);

        // R3 R10: preemption chain with software raise
        raise(7); @(negedge clk);
        expect_grant(7, 8'h80, "R10 level3 swi");
        raise(5); @(negedge clk);
        expect_grant(5, 8'hA0, "R3 preempt");
        retire(7);
        chk(active == 8'hA0, "R4 non-top strobe ignored", active, 8'hA0);
        begin
            bit seen = 0;
            raise(6);
            repeat (3) begin @(negedge clk); if (grant_valid) seen = 1; end
            chk(!seen, "R3 lower waits", seen, 0);
        end
        retire(5);
        chk(active == 8'h80, "R4 retire nested", active, 8'h80);
        @(negedge clk);
        expect_grant(6, 8'hC0, "R3 waiter enters");
        retire(6);
        retire(4);
        chk(active == 8'h80, "R4 inactive strobe ignored", active, 8'h80);
        retire(7);
        retire(2);
        chk(active == '0 && !grant_valid, "R4 idle strobe ignored", active, 0);

        // R12: grant and return on one edge
        raise(6); @(negedge clk);
        expect_grant(6, 8'h40, "R12 setup");
        @(negedge clk); swi_raise[0] = 1'b1;
        @(negedge clk); swi_raise[0] = 1'b0; ret_strobe[6] = 1'b1;
        @(negedge clk); ret_strobe = '0;
        expect_grant(4, 8'h10, "R12 same edge");
        retire(4);

        // R8 R9: every line to every level
        for (int l = 0; l < NLINES; l++) begin
            for (int v = 0; v < NLVL; v++) begin
                cfg(l, 1'b0, v);
                @(negedge clk); periph_req[l] = 1'b1;
                @(negedge clk); periph_req[l] = 1'b0;
                @(negedge clk); @(negedge clk);
                chk(!grant_valid, "R8 not early", grant_valid, 0);
                @(negedge clk);
                expect_grant(4 + v, NCLS'(1) << (4 + v), "R8 line route");
                retire(4 + v);
                cfg(l, 1'b1, v);
            end
        end

        // R9: masked lines stay silent
        for (int l = 0; l < NLINES; l++) begin
            bit seen = 0;
            cfg(l, 1'b1, l % NLVL);
            @(negedge clk); periph_req[l] = 1'b1;
            @(negedge clk); periph_req[l] = 1'b0;
            repeat (5) begin @(negedge clk); if (grant_valid) seen = 1; end
            chk(!seen && active == '0, "R9 masked line", {seen, active}, 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule